// File: doc/BRIEF.md
# Push-Buffer Command Parser

The block walks a command stream that the host has placed in memory. It reads 32-bit words one at a time through a single-word read port. Reading starts at a GET pointer and continues until GET reaches the PUT pointer that the host supplies. Each word is either a control header or a payload word. Headers can redirect GET with plain jumps, with an older jump form, or with a one-level subroutine call and its matching return. Method headers open a run of payload words. A run either steps the method address by 4 on each word or keeps it fixed.

Each payload word leaves the block as a tuple of subchannel, method and data on a valid/ready output. The downstream command cache drops `out_ready` when it is at its high-water mark, and the parser then waits. If the parser meets an illegal header, a misplaced call or return, or a GET outside the buffer, it latches a typed error code and suspends itself. It stays suspended until the host clears it. After each word is consumed, the updated GET is visible on `get_ptr`.

Top module: `pb_parser`

## Requirements
- R1: During and after reset, `get_ptr`, `jmp_shadow`, `data_cnt` and `err_code` read 0, and `suspended`, `sub_active`, `out_valid` and `mem_req` are low.
- R2: A read (`mem_req` high, `mem_addr` = GET) is issued only while `push_en` and `dma_en` are high, `suspended` is low and GET differs from `put_ptr`. `mem_rdata` is taken one cycle after the request, and at most one read is outstanding.
- R3: If GET is greater than or equal to `buf_len` when a read would be issued, no read is made. `err_code` becomes 4 (protection) and `suspended` rises.
- R4: A header with (w & 0xE0000003) == 0x20000000 is an old-style jump. GET becomes w[28:0], and `jmp_shadow` takes the address of the jump word plus 4.
- R5: Otherwise, a header with w[1:0] == 1 is a jump. GET becomes w with bits 1:0 cleared, and `jmp_shadow` takes the jump word's address plus 4.
- R6: Otherwise, a header with w[1:0] == 2 is a call. If `sub_active` is already set, `err_code` becomes 1. If not, the address after the call word is saved as the return address, `sub_active` rises, and GET becomes w with bits 1:0 cleared.
- R7: The exact header 0x00020000 is a return. Without an active subroutine, `err_code` becomes 2. With one, GET is loaded from the saved return address with bits 1:0 cleared, and `sub_active` falls.
- R8: A header with (w & 0xE0030003) == 0 opens an incrementing run, and one equal to 0x40000000 opens a fixed-method run. In both, the method is w[12:0], the subchannel is w[15:13] and the count is w[28:18], and `data_cnt` resets to 0.
- R9: While the count is nonzero, the next word is payload. It is emitted as (subchannel, method, word) and copied to `data_shadow`, the count falls by 1 and `data_cnt` rises by 1. In an incrementing run the 13-bit method advances by 4, wrapping modulo 2^13.
- R10: While `out_valid` is high and `out_ready` is low, the tuple and GET hold steady.
- R11: Any other header gives `err_code` 3. Every error leaves GET on the faulting word, raises `suspended` and stops reads.
- R12: A one-cycle `susp_clr` pulse clears `suspended` and `err_code`. A `get_wr` pulse loads GET from `get_wdata` when no word is in flight. In that cycle it takes priority over starting a read, so the next read uses the new GET.
- R13: After each word that completes without error, `get_ptr` shows the next GET: the word's address plus 4, or the redirect target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_en | input | 1 | Push access enable |
| dma_en | input | 1 | Buffer-fetch access enable |
| susp_clr | input | 1 | Clears suspension and error code |
| get_wr | input | 1 | Load GET from get_wdata |
| get_wdata | input | ADDR_W | New GET byte address |
| put_ptr | input | ADDR_W | PUT byte address (end of valid commands) |
| buf_len | input | ADDR_W | Buffer length in bytes |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read byte address |
| mem_rdata | input | 32 | Read data, one cycle after mem_req |
| out_valid | output | 1 | Tuple valid |
| out_ready | input | 1 | Downstream has room (low at high-water mark) |
| out_subch | output | 3 | Tuple subchannel |
| out_method | output | 13 | Tuple method address |
| out_data | output | 32 | Tuple data word |
| get_ptr | output | ADDR_W | Current GET |
| err_code | output | 3 | 0 none, 1 call, 2 return, 3 reserved, 4 protection |
| suspended | output | 1 | Parser suspended |
| sub_active | output | 1 | Subroutine active |
| jmp_shadow | output | ADDR_W | Address after the last jump word |
| data_shadow | output | 32 | Last payload word |
| data_cnt | output | 11 | Payload words since the last method header |

## Verification
The two functions that can meet in one cycle are the host's GET load and the parser's own decision to start a read. Both are possible while the parser is waiting between words. The bench provokes the collision at the start of every run: in a single cycle it raises `dma_en` and pulses `get_wr`, with GET and PUT already apart. The result is judged by the address of the first read, which must be the newly written GET and never the stale one. Output backpressure is applied in three patterns throughout, so payload stalls overlap header decoding, jumps and the final word before PUT.

// File: rtl/pb_pkg.sv
package pb_pkg;
  localparam int WORD_W = 32;
  localparam int METH_W = 13;
  localparam int SUB_W  = 3;
  localparam int CNT_W  = 11;
  localparam int ERR_W  = 3;

  localparam logic [WORD_W-1:0] RET_WORD = 32'h0002_0000;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE = 3'd0,
    ERR_CALL = 3'd1,
    ERR_RET  = 3'd2,
    ERR_RSVD = 3'd3,
    ERR_PROT = 3'd4
  } pb_err_e;

  typedef enum logic [2:0] {
    K_DATA, K_LJUMP, K_JUMP, K_CALL, K_RET, K_MINC, K_MFIX, K_RSVD
  } pb_kind_e;

  // Header classification; the order of tests sets precedence.
  function automatic pb_kind_e classify(input logic [WORD_W-1:0] w);
    if ((w & 32'hE000_0003) == 32'h2000_0000) return K_LJUMP;
    if (w[1:0] == 2'd1)                        return K_JUMP;
    if (w[1:0] == 2'd2)                        return K_CALL;
    if (w == RET_WORD)                         return K_RET;
    if ((w & 32'hE003_0003) == 32'h0000_0000)  return K_MINC;
    if ((w & 32'hE003_0003) == 32'h4000_0000)  return K_MFIX;
    return K_RSVD;
  endfunction

  function automatic logic [WORD_W-1:0] legacy_target(input logic [WORD_W-1:0] w);
    return w & 32'h1FFF_FFFF;
  endfunction

  function automatic logic [WORD_W-1:0] aligned_target(input logic [WORD_W-1:0] w);
    return w & 32'hFFFF_FFFC;
  endfunction

  function automatic logic [METH_W-1:0] method_step(input logic [METH_W-1:0] m,
                                                   input logic inc);
    return inc ? m + METH_W'(4) : m;
  endfunction
endpackage

// File: rtl/pb_decode.sv
module pb_decode
  import pb_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              cnt_nz,
  output pb_kind_e          kind,
  output logic [METH_W-1:0] hdr_meth,
  output logic [SUB_W-1:0]  hdr_sub,
  output logic [CNT_W-1:0]  hdr_cnt
);
  assign kind     = cnt_nz ? K_DATA : classify(word);
  assign hdr_meth = word[12:0];
  assign hdr_sub  = word[15:13];
  assign hdr_cnt  = word[28:18];
endmodule

// File: rtl/pb_method_track.sv
module pb_method_track
  import pb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_inc,
  input  logic [METH_W-1:0] load_meth,
  input  logic [SUB_W-1:0]  load_sub,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              consume,
  input  logic [WORD_W-1:0] data_in,
  output logic [METH_W-1:0] meth,
  output logic [SUB_W-1:0]  sub,
  output logic              cnt_nz,
  output logic [CNT_W-1:0]  dcnt,
  output logic [WORD_W-1:0] dshadow
);
  logic [CNT_W-1:0] cnt_q;
  logic             inc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meth    <= '0;
      sub     <= '0;
      cnt_q   <= '0;
      inc_q   <= 1'b0;
      dcnt    <= '0;
      dshadow <= '0;
    end else if (load) begin
      meth  <= load_meth;
      sub   <= load_sub;
      cnt_q <= load_cnt;
      inc_q <= load_inc;
      dcnt  <= '0;
    end else if (consume) begin
      meth    <= method_step(meth, inc_q);
      cnt_q   <= cnt_q - CNT_W'(1);
      dcnt    <= dcnt + CNT_W'(1);
      dshadow <= data_in;
    end
  end

  assign cnt_nz = (cnt_q != '0);
endmodule

// File: rtl/pb_return_reg.sv
module pb_return_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_en,
  input  logic              ret_en,
  input  logic [ADDR_W-1:0] ret_in,
  output logic              active,
  output logic [ADDR_W-1:0] ret_addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      ret_addr <= '0;
    end else if (call_en) begin
      active   <= 1'b1;
      ret_addr <= ret_in;
    end else if (ret_en) begin
      active <= 1'b0;
    end
  end
endmodule

// File: rtl/pb_parser.sv
module pb_parser
  import pb_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_en,
  input  logic              dma_en,
  input  logic              susp_clr,
  input  logic              get_wr,
  input  logic [ADDR_W-1:0] get_wdata,
  input  logic [ADDR_W-1:0] put_ptr,
  input  logic [ADDR_W-1:0] buf_len,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_subch,
  output logic [12:0]       out_method,
  output logic [31:0]       out_data,
  output logic [ADDR_W-1:0] get_ptr,
  output logic [2:0]        err_code,
  output logic              suspended,
  output logic              sub_active,
  output logic [ADDR_W-1:0] jmp_shadow,
  output logic [31:0]       data_shadow,
  output logic [10:0]       data_cnt
);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_W / 8);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(3);

  typedef enum logic [1:0] {S_RUN, S_WAIT, S_EXEC} st_e;

  st_e               st_q;
  logic [ADDR_W-1:0] get_q, jsh_q, get_nx, ret_addr;
  logic [WORD_W-1:0] word_q;
  pb_err_e           err_q, err_nx;
  logic              susp_q, cnt_nz, sub_act;
  pb_kind_e          kind;
  logic [METH_W-1:0] hdr_meth, cur_meth;
  logic [SUB_W-1:0]  hdr_sub, cur_sub;
  logic [CNT_W-1:0]  hdr_cnt;

  // Named events
  logic fetch_ok, at_put, out_range;
  logic ev_get_load, ev_fetch, ev_prot;
  logic in_exec, ev_push, ev_hdr, ev_call, ev_ret, ev_jmp, ev_err, ev_done;

  assign fetch_ok    = push_en && dma_en && !susp_q;
  assign at_put      = (get_q == put_ptr);
  assign out_range   = (get_q >= buf_len);
  assign ev_get_load = (st_q == S_RUN) && get_wr;
  assign ev_fetch    = (st_q == S_RUN) && !get_wr && fetch_ok && !at_put && !out_range;
  assign ev_prot     = (st_q == S_RUN) && !get_wr && fetch_ok && !at_put && out_range;

  pb_decode u_dec (
    .word     (word_q),
    .cnt_nz   (cnt_nz),
    .kind     (kind),
    .hdr_meth (hdr_meth),
    .hdr_sub  (hdr_sub),
    .hdr_cnt  (hdr_cnt)
  );

  assign in_exec = (st_q == S_EXEC);

  always_comb begin
    err_nx = ERR_NONE;
    get_nx = get_q + STEP;
    unique case (kind)
      K_LJUMP: get_nx = ADDR_W'(legacy_target(word_q));
      K_JUMP:  get_nx = ADDR_W'(aligned_target(word_q));
      K_CALL: begin
        if (sub_act) err_nx = ERR_CALL;
        get_nx = ADDR_W'(aligned_target(word_q));
      end
      K_RET: begin
        if (!sub_act) err_nx = ERR_RET;
        get_nx = ret_addr & ~LOW_MASK;
      end
      K_RSVD:  err_nx = ERR_RSVD;
      default: ;
    endcase
  end

  assign ev_err  = in_exec && (err_nx != ERR_NONE);
  assign ev_push = in_exec && (kind == K_DATA) && out_ready;
  assign ev_hdr  = in_exec && ((kind == K_MINC) || (kind == K_MFIX));
  assign ev_call = in_exec && (kind == K_CALL) && !ev_err;
  assign ev_ret  = in_exec && (kind == K_RET) && !ev_err;
  assign ev_jmp  = in_exec && ((kind == K_LJUMP) || (kind == K_JUMP));
  assign ev_done = in_exec && !ev_err && ((kind != K_DATA) || out_ready);

  pb_method_track u_meth (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_hdr),
    .load_inc  (kind == K_MINC),
    .load_meth (hdr_meth),
    .load_sub  (hdr_sub),
    .load_cnt  (hdr_cnt),
    .consume   (ev_push),
    .data_in   (word_q),
    .meth      (cur_meth),
    .sub       (cur_sub),
    .cnt_nz    (cnt_nz),
    .dcnt      (data_cnt),
    .dshadow   (data_shadow)
  );

  pb_return_reg #(.ADDR_W(ADDR_W)) u_ret (
    .clk      (clk),
    .rst_n    (rst_n),
    .call_en  (ev_call),
    .ret_en   (ev_ret),
    .ret_in   (get_q + STEP),
    .active   (sub_act),
    .ret_addr (ret_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_RUN;
      get_q  <= '0;
      jsh_q  <= '0;
      word_q <= '0;
      err_q  <= ERR_NONE;
      susp_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_RUN: begin
          if (ev_get_load)   get_q <= get_wdata;
          else if (ev_fetch) st_q  <= S_WAIT;
        end
        S_WAIT: begin
          word_q <= mem_rdata;
          st_q   <= S_EXEC;
        end
        S_EXEC: begin
          if (ev_err) begin
            st_q <= S_RUN;
          end else if (ev_done) begin
            get_q <= get_nx;
            if (ev_jmp) jsh_q <= get_q + STEP;
            st_q <= S_RUN;
          end
        end
        default: st_q <= S_RUN;
      endcase

      if (ev_err) begin
        err_q  <= err_nx;
        susp_q <= 1'b1;
      end else if (ev_prot) begin
        err_q  <= ERR_PROT;
        susp_q <= 1'b1;
      end else if (susp_clr) begin
        err_q  <= ERR_NONE;
        susp_q <= 1'b0;
      end
    end
  end

  assign mem_req    = ev_fetch;
  assign mem_addr   = get_q;
  assign out_valid  = in_exec && (kind == K_DATA);
  assign out_subch  = cur_sub;
  assign out_method = cur_meth;
  assign out_data   = word_q;
  assign get_ptr    = get_q;
  assign err_code   = err_q;
  assign suspended  = susp_q;
  assign sub_active = sub_act;
  assign jmp_shadow = jsh_q;
endmodule

// File: rtl/pb_parser_chk.sv
module pb_parser_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] put_ptr,
  input logic [ADDR_W-1:0] buf_len,
  input logic              out_valid,
  input logic              out_ready,
  input logic [2:0]        out_subch,
  input logic [12:0]       out_method,
  input logic [31:0]       out_data,
  input logic [ADDR_W-1:0] get_ptr,
  input logic [2:0]        err_code,
  input logic              suspended,
  input logic              sub_active,
  input logic [31:0]       data_shadow
);
  p_single_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  p_quiet_susp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !mem_req);
  p_req_not_put_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr != put_ptr);
  p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr < buf_len);
  p_call_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sub_active) |-> err_code == 3'd0);
  p_shadow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> data_shadow == $past(out_data));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) &&
      $stable(out_method) && $stable(out_subch) && $stable(get_ptr));
  p_err_susp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 3'd0) |-> suspended);
endmodule

bind pb_parser pb_parser_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_pb_parser.sv
`timescale 1ns/1ps
module tb_pb_parser;
  localparam int AW = 32;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n, push_en, dma_en, susp_clr, get_wr, out_ready;
  logic [AW-1:0] get_wdata, put_ptr, buf_len;
  logic          mem_req, out_valid, suspended, sub_active;
  logic [AW-1:0] mem_addr, get_ptr, jmp_shadow;
  logic [31:0]   mem_rdata, out_data, data_shadow;
  logic [2:0]    out_subch, err_code;
  logic [12:0]   out_method;
  logic [10:0]   data_cnt;

  pb_parser #(.ADDR_W(AW)) dut (.*);

  int n_checks = 0, n_errs = 0;
  logic [31:0] mem [0:63];

  // Reference model state
  logic [31:0] r_get, r_ret, r_jsh, r_dsh, r_len;
  logic        r_sub, r_inc;
  logic [2:0]  r_err, r_sc;
  logic [12:0] r_meth;
  logic [10:0] r_cnt, r_dcnt;
  logic [47:0] expq[$];

  int          nreq = 0;
  logic [31:0] first_addr = '0;
  int          rmode = 0;
  int          rcnt = 0;
  bit          held = 0;
  logic [47:0] held_t;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Read port: one-cycle latency
  initial begin
    mem_rdata = '0;
    forever begin
      @(posedge clk);
      if (mem_req) mem_rdata <= mem[mem_addr[7:2]];
    end
  end

  // Backpressure patterns
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      rcnt++;
      case (rmode)
        0: out_ready = 1'b1;
        1: out_ready = rcnt[0];
        default: out_ready = (rcnt % 3 == 0);
      endcase
    end
  end

  // Output and request monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (mem_req) begin
          if (nreq == 0) first_addr = mem_addr;
          nreq++;
        end
        if (held) chk(out_valid && {out_subch, out_method, out_data} == held_t,
                      "R10", {out_subch, out_method, out_data}, held_t);
        held = out_valid && !out_ready;
        held_t = {out_subch, out_method, out_data};
        if (out_valid && out_ready) begin
          if (expq.size() == 0) chk(0, "R9", {out_subch, out_method, out_data}, 0);
          else begin
            logic [47:0] e;
            e = expq.pop_front();
            chk({out_subch, out_method, out_data} == e, "R9",
                {out_subch, out_method, out_data}, e);
          end
        end
      end
    end
  end

  task automatic ref_walk(input logic [31:0] p);
    logic [31:0] w, nx;
    for (int g = 0; g < 600 && r_get != p && r_err == 0; g++) begin
      if (r_get >= r_len) begin r_err = 3'd4; break; end
      w  = mem[r_get[7:2]];
      nx = r_get + 32'd4;
      if (r_cnt != 0) begin
        expq.push_back({r_sc, r_meth, w});
        r_dsh = w; r_cnt = r_cnt - 1; r_dcnt = r_dcnt + 1;
        if (r_inc) r_meth = r_meth + 13'd4;
        r_get = nx;
      end else if ((w & 32'hE0000003) == 32'h20000000) begin
        r_jsh = nx; r_get = {3'b000, w[28:0]};
      end else if (w[1:0] == 2'd1) begin
        r_jsh = nx; r_get = {w[31:2], 2'b00};
      end else if (w[1:0] == 2'd2) begin
        if (r_sub) r_err = 3'd1;
        else begin r_ret = nx; r_sub = 1; r_get = {w[31:2], 2'b00}; end
      end else if (w == 32'h00020000) begin
        if (!r_sub) r_err = 3'd2;
        else begin r_get = {r_ret[31:2], 2'b00}; r_sub = 0; end
      end else if ((w & 32'hE0030003) == 0 || (w & 32'hE0030003) == 32'h40000000) begin
        r_meth = w[12:0]; r_sc = w[15:13]; r_cnt = w[28:18];
        r_inc = ((w & 32'hE0030003) == 0); r_dcnt = 0; r_get = nx;
      end else r_err = 3'd3;
    end
  endtask

  task automatic launch(input logic [31:0] g, input logic [31:0] p, input string etag);
    int guard;
    put_ptr = p;
    r_len = buf_len;
    r_get = g;
    expq.delete();
    ref_walk(p);
    nreq = 0;
    @(posedge clk); #1;
    dma_en = 1'b1; get_wr = 1'b1; get_wdata = g;   // R12: load collides with fetch start
    @(posedge clk); #1;
    get_wr = 1'b0;
    guard = 0;
    do begin @(negedge clk); guard++; end
    while (!(get_ptr == p || suspended) && guard < 3000);
    repeat (4) @(negedge clk);
    chk(guard < 3000, "R2", guard, 3000);
    if (g != p && g < r_len) chk(first_addr == g, "R12", first_addr, g);
    chk(get_ptr == r_get, "R13", get_ptr, r_get);
    chk(err_code == r_err, etag, err_code, r_err);
    chk(suspended == (r_err != 0), "R11", suspended, r_err != 0);
    chk(sub_active == r_sub, "R6", sub_active, r_sub);
    chk(jmp_shadow == r_jsh, "R4", jmp_shadow, r_jsh);
    chk(data_cnt == r_dcnt, "R8", data_cnt, r_dcnt);
    chk(data_shadow == r_dsh, "R9", data_shadow, r_dsh);
    chk(expq.size() == 0, "R9", expq.size(), 0);
    @(posedge clk); #1;
    dma_en = 1'b0;
  endtask

  task automatic clear_susp();
    @(posedge clk); #1; dma_en = 1'b0; susp_clr = 1'b1;
    @(posedge clk); #1; susp_clr = 1'b0;
    r_err = 0;
    @(negedge clk);
    chk(!suspended && err_code == 0, "R12", {suspended, err_code}, 0);
  endtask

  initial begin
    #(4ns * 200000);
    n_errs++; n_checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    rst_n = 0; push_en = 1; dma_en = 0; susp_clr = 0; get_wr = 0;
    get_wdata = '0; put_ptr = '0; buf_len = 32'h100;
    r_get = 0; r_ret = 0; r_jsh = 0; r_dsh = 0; r_len = 32'h100;
    r_sub = 0; r_inc = 0; r_err = 0; r_sc = 0; r_meth = 0; r_cnt = 0; r_dcnt = 0;
    repeat (3) @(negedge clk);
    chk(get_ptr == 0 && jmp_shadow == 0 && data_cnt == 0 && err_code == 0, "R1",
        {get_ptr, err_code}, 0);
    chk(!suspended && !sub_active && !out_valid && !mem_req, "R1",
        {suspended, sub_active, out_valid, mem_req}, 0);
    @(posedge clk); #1 rst_n = 1;

    // Mixed runs with jumps, call and return
    mem[0]  = 32'h2000_0020;
    mem[8]  = 32'h0000_0041;
    mem[16] = 32'h0000_0082;
    mem[32] = (32'd2 << 18) | (32'd2 << 13) | 32'h10;
    mem[33] = 32'hDEAD_0001;
    mem[34] = 32'hDEAD_0002;
    mem[35] = 32'h0002_0000;
    mem[17] = 32'h4000_0000 | (32'd2 << 18) | (32'd1 << 13) | 32'h20;
    mem[18] = 32'hBEEF_0002;
    mem[19] = 32'hBEEF_0003;
    for (int m = 0; m < 3; m++) begin
      rmode = m;
      launch(32'h0, 32'h50, "R5");
    end

    // Gating: one enable low means no reads (R2)
    put_ptr = 32'h10;
    @(posedge clk); #1 get_wr = 1; get_wdata = 32'h0;
    @(posedge clk); #1 get_wr = 0; push_en = 0; dma_en = 1; nreq = 0;
    repeat (20) @(negedge clk);
    chk(nreq == 0 && get_ptr == 0, "R2", nreq, 0);
    @(posedge clk); #1 push_en = 1; dma_en = 0;
    repeat (20) @(negedge clk);
    chk(nreq == 0 && get_ptr == 0, "R2", nreq, 0);

    // Call while active (R6), then return without subroutine (R7)
    rmode = 0;
    mem[0] = 32'h0000_0012;
    mem[4] = 32'h0000_0022;
    launch(32'h0, 32'h80, "R6");
    nreq = 0;
    @(posedge clk); #1 dma_en = 1;
    repeat (20) @(negedge clk);
    chk(nreq == 0 && get_ptr == 32'h10, "R11", {nreq, get_ptr}, 32'h10);
    clear_susp();
    mem[4] = 32'h0002_0000;
    mem[1] = 32'h0002_0000;
    launch(32'h10, 32'h80, "R7");
    clear_susp();

    // Reserved headers (R11)
    mem[0] = 32'h0000_0003;
    launch(32'h0, 32'h10, "R11");
    clear_susp();
    mem[0] = 32'h0001_0000;
    launch(32'h0, 32'h10, "R11");
    clear_susp();
    mem[0] = 32'hA000_0000;
    launch(32'h0, 32'h10, "R11");
    clear_susp();

    // Protection (R3)
    buf_len = 32'h40;
    launch(32'h40, 32'h50, "R3");
    chk(nreq == 0, "R3", nreq, 0);
    clear_susp();
    mem[14] = (32'd3 << 18) | 32'h4;
    for (int i = 15; i < 18; i++) mem[i] = 32'h0C00_0000 + i;
    launch(32'h38, 32'h48, "R3");
    clear_susp();
    buf_len = 32'h100;

    // Sweep: run type x count x subchannel (R8, R9, R10)
    for (int k = 0; k < 2; k++)
      for (int c = 0; c < 6; c++)
        for (int s = 0; s < 8; s++) begin
          logic [31:0] h;
          h = (k == 1 ? 32'h4000_0000 : 32'h0) | (32'(c) << 18) | (32'(s) << 13) |
              (32'h1FE0 + 32'(s) * 4);
          mem[0] = h;
          for (int d = 1; d <= 6; d++) mem[d] = {8'(k), 8'(c), 8'(s), 8'(d)};
          rmode = (c + s) % 3;
          launch(32'h0, 32'(4 * (c + 1)), "R8");
        end

    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule